// File: doc/BRIEF.md
# Slow-Idle Clock Enable Divider

This block produces the clock enables that pace a processor core and its peripherals. In normal run, the core enable and every derived enable (serial bit clock, clock output, timer tick) advance at full rate. The core issues an idle command with an optional divisor. Without a divisor, the core stalls and the peripherals keep running at full rate. With a divisor, the common base tick is slowed by a power-of-two ratio from 16 to 128, so that every derived enable slows by that same ratio.

While idle, cycle-steal requests from the DMA and autobuffer engines are still granted, once per base tick. An unmasked interrupt ends the idle state. Standard idle wakes in the same cycle. Slow idle wakes on the next divided tick. In both cases a one-cycle resume strobe tells the core to continue with the instruction after the idle. The block contains no interrupt controller and no DMA engine; it carries only their request and grant lines.

Top module: `slowidle_clkdiv`

## Requirements
- R1: After reset the block is in run: core_en is 1, resume and steal_gnt are 0, and clkout_en is 1 while clkout_dis is 0.
- R2: The 2-bit idle_code selects the ratio n: 00 gives 16, 01 gives 32, 10 gives 64 and 11 gives 128. Cycle 0 of an idle is the cycle after the edge that samples idle_req. In slow idle the base tick occurs in every cycle k with k mod n = n-1.
- R3: A run-state idle_req with idle_slow at 0 enters standard idle. core_en falls to 0, while clkout_en (with clkout_dis at 0) and the other derived enables keep the full-rate pattern.
- R4: In standard idle, irq at 1 raises resume in that same cycle, and core_en returns to 1 in the next cycle.
- R5: In slow idle, an irq seen in cycle d is remembered even if it lasts only one cycle. resume rises in the first tick cycle k >= d, so the wait is at most n cycles. core_en returns to 1 in the cycle after resume.
- R6: sclk_en fires once every SCLK_DIV base ticks and timer_en once every TMR_DIV base ticks. Their periods are therefore SCLK_DIV and TMR_DIV cycles in run, and n times longer in slow idle.
- R7: clkout_en equals the base tick while clkout_dis is 0, and stays 0 while clkout_dis is 1.
- R8: steal_gnt equals steal_req in run and in standard idle. In slow idle a held request is granted only in tick cycles.
- R9: idle_req is ignored outside run. A second command during slow idle does not change the ratio in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, full processor rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_req | input | 1 | One-cycle idle command from the core |
| idle_slow | input | 1 | Set when the command carries a divisor |
| idle_code | input | 2 | Divisor code (00:16, 01:32, 10:64, 11:128) |
| irq | input | 1 | Unmasked interrupt pending |
| steal_req | input | 1 | DMA / autobuffer cycle-steal request |
| clkout_dis | input | 1 | Gates the clock output enable off |
| core_en | output | 1 | Core clock enable (0 while idle) |
| resume | output | 1 | Strobe: continue after the idle instruction |
| clkout_en | output | 1 | Clock-output enable |
| sclk_en | output | 1 | Serial bit-clock enable |
| timer_en | output | 1 | Timer tick enable |
| steal_gnt | output | 1 | Cycle-steal grant |

## Verification
Wake-up and cycle-steal grant can fall in the same cycle, because both are released by the same divided tick. The bench holds steal_req high through a slow idle and raises irq several cycles before a tick. It then checks that resume and steal_gnt both assert in that one tick cycle, and that neither asserts in the cycles before it. A second coincidence is an irq that arrives exactly in a tick cycle. That case must wake in the same cycle rather than one period later, and it is covered by a table vector.

// File: rtl/slowidle_pkg.sv
package slowidle_pkg;

  localparam int DIV_CODE_W = 2;
  localparam int DIV_CNT_W  = 7;
  localparam int DIV_MIN_SH = 4;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_IDLE = 2'd1,
    MODE_SLOW = 2'd2
  } mode_e;

  // Ratio n for a divisor code: 16 shifted left by the code.
  function automatic logic [DIV_CNT_W:0] div_ratio(input logic [DIV_CODE_W-1:0] code);
    logic [DIV_CNT_W:0] base;
    base = (DIV_CNT_W+1)'(1) << DIV_MIN_SH;
    return base << code;
  endfunction

  // Low-bit mask n-1 used for the tick compare.
  function automatic logic [DIV_CNT_W-1:0] div_mask(input logic [DIV_CODE_W-1:0] code);
    logic [DIV_CNT_W:0] r;
    r = div_ratio(code) - (DIV_CNT_W+1)'(1);
    return r[DIV_CNT_W-1:0];
  endfunction

endpackage

// File: rtl/slowidle_tick_gen.sv
module slowidle_tick_gen
  import slowidle_pkg::*;
#(
  parameter int CNT_W  = DIV_CNT_W,
  parameter int CODE_W = DIV_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              slow_active,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;
  logic             div_pulse;

  assign mask      = CNT_W'(div_mask(code));
  assign div_pulse = ((cnt_q & mask) == mask);
  assign tick      = slow_active ? div_pulse : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clear)  cnt_q <= '0;
    else             cnt_q <= cnt_q + CNT_W'(1);
  end

  // Independent gap counter: cycles since slow entry or the last tick.
  logic [CNT_W-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   gap_q <= '0;
    else if (clear || !slow_active || div_pulse) gap_q <= '0;
    else                                          gap_q <= gap_q + CNT_W'(1);
  end

  // R2
  slow_tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_active && tick) |-> (gap_q == mask));

endmodule

// File: rtl/slowidle_prescale.sv
module slowidle_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic en
);

  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pcnt_q;

  assign en = tick && (pcnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pcnt_q <= '0;
    else if (en)   pcnt_q <= '0;
    else if (tick) pcnt_q <= pcnt_q + PW'(1);
  end

  // R6
  prescale_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> tick);

  // R6
  prescale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pcnt_q));

endmodule

// File: rtl/slowidle_mode_ctl.sv
module slowidle_mode_ctl
  import slowidle_pkg::*;
#(
  parameter int CNT_W  = DIV_CNT_W,
  parameter int CODE_W = DIV_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle_req,
  input  logic              idle_slow,
  input  logic [CODE_W-1:0] idle_code,
  input  logic              irq,
  input  logic              tick,
  output mode_e             mode_q,
  output logic [CODE_W-1:0] code_q,
  output logic              enter_slow,
  output logic              wake
);

  logic  accept;
  logic  wake_std;
  logic  wake_slow;
  logic  pend_q;
  mode_e mode_d;

  assign accept     = (mode_q == MODE_RUN) && idle_req;
  assign enter_slow = accept && idle_slow;
  assign wake_std   = (mode_q == MODE_IDLE) && irq;
  assign wake_slow  = (mode_q == MODE_SLOW) && tick && (irq || pend_q);
  assign wake       = wake_std || wake_slow;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_RUN:  if (accept) mode_d = idle_slow ? MODE_SLOW : MODE_IDLE;
      MODE_IDLE: if (wake_std) mode_d = MODE_RUN;
      MODE_SLOW: if (wake_slow) mode_d = MODE_RUN;
      default:   mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RUN;
      code_q <= '0;
      pend_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      if (accept) code_q <= idle_code;
      if (mode_q != MODE_SLOW || wake_slow) pend_q <= 1'b0;
      else if (irq)                         pend_q <= 1'b1;
    end
  end

  // Wait counter: cycles an interrupt has been held off in slow idle.
  logic [CNT_W-1:0] wait_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_q <= '0;
    else if (mode_q == MODE_SLOW && (irq || pend_q) && !wake_slow)
      wait_q <= wait_q + CNT_W'(1);
    else
      wait_q <= '0;
  end

  // R5
  wake_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SLOW && (irq || pend_q)) |-> (wait_q <= CNT_W'(div_mask(code_q))));

  // R9
  code_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_RUN) |=> $stable(code_q));

  // R4
  std_idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_IDLE && irq) |=> (mode_q == MODE_RUN));

endmodule

// File: rtl/slowidle_clkdiv.sv
module slowidle_clkdiv
  import slowidle_pkg::*;
#(
  parameter int CNT_W    = DIV_CNT_W,
  parameter int CODE_W   = DIV_CODE_W,
  parameter int SCLK_DIV = 4,
  parameter int TMR_DIV  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle_req,
  input  logic              idle_slow,
  input  logic [CODE_W-1:0] idle_code,
  input  logic              irq,
  input  logic              steal_req,
  input  logic              clkout_dis,
  output logic              core_en,
  output logic              resume,
  output logic              clkout_en,
  output logic              sclk_en,
  output logic              timer_en,
  output logic              steal_gnt
);

  mode_e             mode_q;
  logic [CODE_W-1:0] code_q;
  logic              enter_slow;
  logic              wake;
  logic              tick;
  logic              slow_active;

  assign slow_active = (mode_q == MODE_SLOW);

  slowidle_mode_ctl #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .idle_req   (idle_req),
    .idle_slow  (idle_slow),
    .idle_code  (idle_code),
    .irq        (irq),
    .tick       (tick),
    .mode_q     (mode_q),
    .code_q     (code_q),
    .enter_slow (enter_slow),
    .wake       (wake)
  );

  slowidle_tick_gen #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_tick (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (enter_slow),
    .slow_active (slow_active),
    .code        (code_q),
    .tick        (tick)
  );

  slowidle_prescale #(.DIV(SCLK_DIV)) u_sclk (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .en    (sclk_en)
  );

  slowidle_prescale #(.DIV(TMR_DIV)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .en    (timer_en)
  );

  assign core_en   = (mode_q == MODE_RUN);
  assign resume    = wake;
  assign clkout_en = tick && !clkout_dis;
  assign steal_gnt = steal_req && tick;

  // R1
  run_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> !core_en);

  // R4
  std_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_IDLE && irq) |=> core_en);

  // R3
  std_idle_full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_IDLE && !clkout_dis) |-> clkout_en);

  // R7
  clkout_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clkout_en |-> !clkout_dis);

  // R8
  steal_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    steal_gnt |-> steal_req);

  // R8
  steal_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_en && steal_req) |-> steal_gnt);

endmodule

// File: tb/tb_slowidle_clkdiv.sv
module tb_slowidle_clkdiv;

  localparam int SCLK_DIV = 4;
  localparam int TMR_DIV  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic idle_req = 1'b0, idle_slow = 1'b0, irq = 1'b0, steal_req = 1'b0, clkout_dis = 1'b0;
  logic [1:0] idle_code = 2'b00;
  logic core_en, resume, clkout_en, sclk_en, timer_en, steal_gnt;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  slowidle_clkdiv #(.SCLK_DIV(SCLK_DIV), .TMR_DIV(TMR_DIV)) dut (
    .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .idle_slow(idle_slow),
    .idle_code(idle_code), .irq(irq), .steal_req(steal_req), .clkout_dis(clkout_dis),
    .core_en(core_en), .resume(resume), .clkout_en(clkout_en), .sclk_en(sclk_en),
    .timer_en(timer_en), .steal_gnt(steal_gnt)
  );

  // Vectors: {slow, code, irq cycle}
  localparam int NV = 8;
  localparam logic [10:0] VEC [NV] = '{
    {1'b1, 2'b00, 8'd0},   {1'b1, 2'b00, 8'd15}, {1'b1, 2'b01, 8'd5},
    {1'b1, 2'b01, 8'd40},  {1'b1, 2'b10, 8'd63}, {1'b1, 2'b11, 8'd100},
    {1'b0, 2'b00, 8'd0},   {1'b0, 2'b00, 8'd7}
  };

  function automatic int ratio_of(input logic [1:0] c);
    case (c)
      2'b00: return 16;
      2'b01: return 32;
      2'b10: return 64;
      default: return 128;
    endcase
  endfunction

  function automatic int expect_wake(input bit slow, input int n, input int d);
    if (!slow) return d;
    return ((d / n) + 1) * n - 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic enter_idle(input bit slow, input logic [1:0] code);
    @(negedge clk);
    idle_req = 1'b1; idle_slow = slow; idle_code = code;
    @(negedge clk);
    idle_req = 1'b0; idle_slow = 1'b0;
  endtask

  // Hold irq until resume; leaves the block in run.
  task automatic wake_up();
    bit seen = 1'b0;
    for (int i = 0; i < 300 && !seen; i++) begin
      if (i > 0) @(negedge clk);
      irq = 1'b1;
      #1;
      if (resume) seen = 1'b1;
    end
    @(negedge clk);
    irq = 1'b0;
  endtask

  // Gap in cycles between two successive pulses of sclk_en (sel 0) or timer_en (sel 1).
  task automatic measure_gap(input int sel, output int gap);
    int first = -1;
    gap = -1;
    for (int c = 0; c < 600 && gap < 0; c++) begin
      @(negedge clk);
      #1;
      if ((sel == 0) ? sclk_en : timer_en) begin
        if (first < 0) first = c;
        else gap = c - first;
      end
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : main
    int got;
    int gap;
    bit seen;
    bit tick_ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    chk(core_en == 1'b1, "R1 core_en", core_en, 1);
    chk(resume == 1'b0, "R1 resume", resume, 0);
    chk(steal_gnt == 1'b0, "R1 steal_gnt", steal_gnt, 0);
    chk(clkout_en == 1'b1, "R1 clkout_en", clkout_en, 1);

    // Table walk: R2 ticks, R3/R4 standard idle, R5 slow wake
    for (int v = 0; v < NV; v++) begin
      bit slow = VEC[v][10];
      logic [1:0] code = VEC[v][9:8];
      int d = int'(VEC[v][7:0]);
      int n = ratio_of(code);
      int exp = expect_wake(slow, n, d);
      enter_idle(slow, code);
      seen = 1'b0; got = -1; tick_ok = 1'b1;
      for (int k = 0; k < 300 && !seen; k++) begin
        if (k > 0) @(negedge clk);
        irq = (k == d);
        #1;
        if (clkout_en != (slow ? ((k % n) == n - 1) : 1'b1)) tick_ok = 1'b0;
        if (core_en) tick_ok = 1'b0;
        if (resume) begin seen = 1'b1; got = k; end
      end
      chk(tick_ok, slow ? "R2 slow tick pattern" : "R3 std idle full rate", tick_ok, 1);
      chk(got == exp, slow ? "R5 slow wake cycle" : "R4 std wake cycle", got, exp);
      @(negedge clk);
      irq = 1'b0;
      #1;
      chk(core_en == 1'b1, slow ? "R5 core_en after resume" : "R4 core_en after resume", core_en, 1);
    end

    // R6 derived periods in run
    measure_gap(0, gap);
    chk(gap == SCLK_DIV, "R6 sclk run period", gap, SCLK_DIV);
    measure_gap(1, gap);
    chk(gap == TMR_DIV, "R6 timer run period", gap, TMR_DIV);

    // R6 derived periods in slow idle, ratio 16
    enter_idle(1'b1, 2'b00);
    measure_gap(0, gap);
    chk(gap == SCLK_DIV * 16, "R6 sclk slow period", gap, SCLK_DIV * 16);
    measure_gap(1, gap);
    chk(gap == TMR_DIV * 16, "R6 timer slow period", gap, TMR_DIV * 16);
    wake_up();

    // R7 clkout disable, in run and in standard idle
    clkout_dis = 1'b1;
    @(negedge clk); #1;
    chk(clkout_en == 1'b0, "R7 clkout gated in run", clkout_en, 0);
    enter_idle(1'b0, 2'b00);
    #1;
    chk(clkout_en == 1'b0, "R7 clkout gated in idle", clkout_en, 0);
    wake_up();
    clkout_dis = 1'b0;
    @(negedge clk); #1;
    chk(clkout_en == 1'b1, "R7 clkout restored", clkout_en, 1);

    // R8 steal in run and standard idle
    steal_req = 1'b1;
    #1;
    chk(steal_gnt == 1'b1, "R8 steal in run", steal_gnt, 1);
    enter_idle(1'b0, 2'b00);
    #1;
    chk(steal_gnt == 1'b1, "R8 steal in std idle", steal_gnt, 1);
    wake_up();

    // R8 + R5 coincidence: steal held, irq at cycle 3, ratio 16 -> both at cycle 15
    enter_idle(1'b1, 2'b00);
    seen = 1'b0; got = -1; tick_ok = 1'b1;
    for (int k = 0; k < 40 && !seen; k++) begin
      if (k > 0) @(negedge clk);
      irq = (k == 3);
      #1;
      if (steal_gnt != ((k % 16) == 15)) tick_ok = 1'b0;
      if (resume) begin
        seen = 1'b1; got = k;
        chk(steal_gnt == 1'b1, "R8 grant with wake", steal_gnt, 1);
      end
    end
    chk(tick_ok, "R8 slow grant only on tick", tick_ok, 1);
    chk(got == 15, "R5 wake with steal", got, 15);
    @(negedge clk);
    irq = 1'b0; steal_req = 1'b0;

    // R9 second command during slow idle ignored (ratio stays 16, not 128)
    enter_idle(1'b1, 2'b00);
    seen = 1'b0; got = -1;
    for (int k = 0; k < 200 && !seen; k++) begin
      if (k > 0) @(negedge clk);
      idle_req = (k == 2); idle_slow = (k == 2); idle_code = 2'b11;
      #1;
      if (clkout_en) begin seen = 1'b1; got = k; end
    end
    idle_req = 1'b0; idle_slow = 1'b0;
    chk(got == 15, "R9 ratio unchanged", got, 15);
    @(negedge clk);
    seen = 1'b0; got = -1;
    for (int k = 16; k < 200 && !seen; k++) begin
      if (k > 16) @(negedge clk);
      #1;
      if (clkout_en) begin seen = 1'b1; got = k; end
    end
    chk(got == 31, "R9 second period unchanged", got, 31);
    wake_up();
    #1;
    chk(core_en == 1'b1, "R9 back in run", core_en, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule